// File: doc/BRIEF.md
# AUX Channel Request Engine

This block runs single request/reply exchanges on a display auxiliary channel on behalf of software. Software reaches it through a small word-addressed register port. It loads a target address, fills up to sixteen payload bytes into a transmit buffer and writes a control word. The control word names the command, gives the length and sets the start bit. The engine freezes that request and presents it as a descriptor to a link-side agent. The agent owns the line coding. The engine then waits for a reply or for its own timeout to expire.

When the exchange ends, the engine records several results in a status register: the reply class, the number of bytes received and a group of sticky error flags. Read replies are copied into a receive buffer of the same size. A done cause is raised, and it drives an interrupt line through an enable bit.

Register word offsets: 0 target address, 1 control, 2 status, 3 interrupt cause, 4 interrupt enable, 8 to 11 transmit words 0 to 3, 12 to 15 receive words 0 to 3 (read only). Reads of any other offset return zero.

Top module: `aux_xact_ctrl`

## Requirements
- R1: After reset every register reads zero, `link_req` is low and `irq` is low.
- R2: Buffers pack bytes little-endian: payload byte k sits in word k/4 at bits 8*(k%4)+7 down to 8*(k%4), on both `link_tx_data` (byte k at bits 8k+7:8k) and the receive words read back from `link_rx_data`.
- R3: Control bits [3:0] hold the byte count minus one; a started non-empty request presents `link_len` equal to that field plus one, so at most 16 bytes are ever requested.
- R4: Control bit 8 marks an address-only request, presented with `link_len` 0 and `link_addr_only` high; it is started only for command codes 2, 3 and 4, and otherwise the start bit is dropped and `link_req` stays low.
- R5: Control bits [14:12] select the command: 0 native write, 1 native read, 2 I2C write, 3 I2C read, 4 I2C status-update request; codes 5 to 7 never start. Bit 15 requests the middle-of-transaction variant and reaches `link_mot` only for codes 2 to 4.
- R6: Writing control bit 16 as one while idle starts a request. `link_req` then stays high until a reply or a timeout. Control bit 16 reads one while the request is outstanding and zero once it ends.
- R7: While a request is outstanding, writes to the address, control and transmit registers are ignored.
- R8: On a reply, status [19:16] takes the reply class (0 native ACK, 1 native NACK, 2 native DEFER, 4 I2C NACK, 8 I2C DEFER) and status [4:0] takes the received count. Reply error bits rx/sink/stop set status bits 9/10/11. The receive buffer is loaded only for command codes 1 and 3.
- R9: If no reply arrives, the request ends after TIMEOUT_CYCLES cycles of `link_req` high. Status bit 8 is set, the reply class and count read zero, and the receive buffer is left unchanged.
- R10: Status error bits [11:8] are sticky across requests and clear only where a status write carries a one; all other status bits ignore writes.
- R11: Interrupt cause bit 0 sets when a request ends and clears on a write of one. When both happen in the same cycle, the set wins. `irq` equals cause bit 0 ANDed with enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| link_req | output | 1 | Request outstanding to the link agent |
| link_addr | output | ADDR_W | Target address of the request |
| link_cmd | output | 3 | Command code |
| link_mot | output | 1 | Middle-of-transaction flag (I2C only) |
| link_addr_only | output | 1 | Address-only request |
| link_len | output | 5 | Requested byte count, 0 to 16 |
| link_tx_data | output | 128 | Transmit payload, byte k at bits 8k+7:8k |
| link_rsp_valid | input | 1 | One-cycle reply strobe |
| link_rsp_type | input | 4 | Reply class |
| link_rsp_count | input | 5 | Bytes received |
| link_rsp_err | input | 3 | Reply errors: bit0 rx, bit1 sink status, bit2 missing stop |
| link_rx_data | input | 128 | Received payload, byte k at bits 8k+7:8k |
| irq | output | 1 | Done interrupt |

## Verification
The hardest situation to reach from the ports is software clearing the done cause in the very cycle the reply arrives. The bench builds it by driving the cause write and the reply strobe on the same clock edge, and then expects the cause still set. The illegal-start and busy-write cases also need their own stimulus. Their effect shows only as the absence of a change, so the bench reads the descriptor and buffer back afterwards. The timeout path is reached by withholding the reply and counting the cycles for which `link_req` stays high. Randomized transactions then mix command codes, lengths, address-only requests, reply classes and error flags.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

    localparam int BUF_WORDS = 4;
    localparam int BUF_BYTES = BUF_WORDS * 4;
    localparam int LEN_W     = $clog2(BUF_BYTES);
    localparam int CNT_W     = $clog2(BUF_BYTES + 1);
    localparam int REG_AW    = 4;
    localparam int CMD_W     = 3;

    localparam logic [REG_AW-1:0] RA_ADDR  = 4'd0;
    localparam logic [REG_AW-1:0] RA_CTRL  = 4'd1;
    localparam logic [REG_AW-1:0] RA_STAT  = 4'd2;
    localparam logic [REG_AW-1:0] RA_CAUSE = 4'd3;
    localparam logic [REG_AW-1:0] RA_EN    = 4'd4;

    localparam int CB_ADDR_ONLY = 8;
    localparam int CB_CMD_LO    = 12;
    localparam int CB_MOT       = 15;
    localparam int CB_GO        = 16;
    localparam int SB_ERR_LO    = 8;
    localparam int SB_TYPE_LO   = 16;

    typedef enum logic [CMD_W-1:0] {
        CMD_NAT_WR   = 3'd0,
        CMD_NAT_RD   = 3'd1,
        CMD_I2C_WR   = 3'd2,
        CMD_I2C_RD   = 3'd3,
        CMD_I2C_STAT = 3'd4
    } aux_cmd_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             mot;
        logic             addr_only;
        logic [CNT_W-1:0] len;
    } aux_desc_t;

    function automatic logic cmd_is_i2c(input logic [CMD_W-1:0] c);
        return (c == CMD_I2C_WR) || (c == CMD_I2C_RD) || (c == CMD_I2C_STAT);
    endfunction

    function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
        return (c == CMD_NAT_RD) || (c == CMD_I2C_RD);
    endfunction

    function automatic logic cmd_known(input logic [CMD_W-1:0] c);
        return c <= CMD_I2C_STAT;
    endfunction

endpackage

// File: rtl/aux_cmd_decode.sv
module aux_cmd_decode
    import aux_xact_pkg::*;
(
    input  logic [15:0] ctrl_word,
    output aux_desc_t   desc,
    output logic        legal
);
    logic [CMD_W-1:0] c;
    logic             ao;

    always_comb begin
        c  = ctrl_word[CB_CMD_LO +: CMD_W];
        ao = ctrl_word[CB_ADDR_ONLY];
        desc.cmd       = c;
        desc.addr_only = ao;
        desc.mot       = ctrl_word[CB_MOT] & cmd_is_i2c(c);
        // length field is count minus one; address-only requests carry none
        desc.len       = ao ? '0 : (CNT_W'(ctrl_word[LEN_W-1:0]) + CNT_W'(1));
        legal          = cmd_known(c) && (!ao || cmd_is_i2c(c));
    end
endmodule

// File: rtl/aux_word_buf.sv
module aux_word_buf #(
    parameter int WORDS = 4,
    parameter int WIDTH = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WORDS-1:0]       wr_en,
    input  logic [WORDS*WIDTH-1:0] wr_data,
    output logic [WORDS*WIDTH-1:0] q
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WIDTH-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en[w])
                word_q <= wr_data[w*WIDTH +: WIDTH];
        end
        assign q[w*WIDTH +: WIDTH] = word_q;
    end
endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
    import aux_xact_pkg::*;
#(
    parameter int ADDR_W         = 20,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [3:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    link_req,
    output logic [ADDR_W-1:0]       link_addr,
    output logic [2:0]              link_cmd,
    output logic                    link_mot,
    output logic                    link_addr_only,
    output logic [4:0]              link_len,
    output logic [127:0]            link_tx_data,
    input  logic                    link_rsp_valid,
    input  logic [3:0]              link_rsp_type,
    input  logic [4:0]              link_rsp_count,
    input  logic [2:0]              link_rsp_err,
    input  logic [127:0]            link_rx_data,
    output logic                    irq
);
    localparam int DATA_W = BUF_WORDS * 32;
    localparam int TMO_W  = $clog2(TIMEOUT_CYCLES + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       ctrl_q;
    aux_desc_t         desc_q;
    aux_desc_t         dec_desc;
    logic              dec_legal;
    logic              busy_q;
    logic [TMO_W-1:0]  tmo_cnt;
    logic [3:0]        err_q;
    logic [3:0]        type_q;
    logic [4:0]        cnt_q;
    logic              cause_q;
    logic              en_q;

    logic              wr_ok;
    logic              tmo_hit;
    logic              done;
    logic [3:0]        err_set;
    logic [3:0]        err_clr;
    logic              cause_clr;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [BUF_WORDS-1:0] tx_we;
    logic [BUF_WORDS-1:0] rx_we;

    aux_cmd_decode u_dec (
        .ctrl_word (reg_wdata[15:0]),
        .desc      (dec_desc),
        .legal     (dec_legal)
    );

    assign wr_ok   = reg_we && !busy_q;
    assign tmo_hit = busy_q && !link_rsp_valid && (tmo_cnt == TMO_W'(TIMEOUT_CYCLES - 1));
    assign done    = busy_q && (link_rsp_valid || tmo_hit);

    always_comb begin
        err_set = '0;
        if (done)
            err_set = {(link_rsp_valid ? link_rsp_err : 3'b000), tmo_hit};
        err_clr   = (reg_we && reg_addr == RA_STAT) ? reg_wdata[SB_ERR_LO +: 4] : 4'b0;
        cause_clr = reg_we && (reg_addr == RA_CAUSE) && reg_wdata[0];
    end

    // transmit buffer: bus writes at offsets 8..11, frozen while busy
    always_comb begin
        for (int w = 0; w < BUF_WORDS; w++)
            tx_we[w] = wr_ok && (reg_addr[3:2] == 2'b10) && (reg_addr[1:0] == 2'(w));
        rx_we = {BUF_WORDS{busy_q && link_rsp_valid && cmd_is_read(desc_q.cmd)}};
    end

    aux_word_buf #(.WORDS(BUF_WORDS), .WIDTH(32)) u_txbuf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tx_we),
        .wr_data ({BUF_WORDS{reg_wdata}}),
        .q       (tx_q)
    );

    aux_word_buf #(.WORDS(BUF_WORDS), .WIDTH(32)) u_rxbuf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rx_we),
        .wr_data (link_rx_data),
        .q       (rx_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            ctrl_q  <= '0;
            desc_q  <= '0;
            busy_q  <= 1'b0;
            tmo_cnt <= '0;
            err_q   <= '0;
            type_q  <= '0;
            cnt_q   <= '0;
            cause_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            if (wr_ok && reg_addr == RA_ADDR)
                addr_q <= reg_wdata[ADDR_W-1:0];
            if (wr_ok && reg_addr == RA_CTRL) begin
                ctrl_q <= reg_wdata[15:0];
                if (reg_wdata[CB_GO] && dec_legal) begin
                    busy_q <= 1'b1;
                    desc_q <= dec_desc;
                end
            end
            tmo_cnt <= busy_q ? tmo_cnt + TMO_W'(1) : '0;
            if (done) begin
                busy_q <= 1'b0;
                type_q <= link_rsp_valid ? link_rsp_type  : 4'b0;
                cnt_q  <= link_rsp_valid ? link_rsp_count : 5'b0;
            end
            err_q   <= (err_q & ~err_clr) | err_set;
            cause_q <= (cause_q & ~cause_clr) | done;
            if (reg_we && reg_addr == RA_EN)
                en_q <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_ADDR:  reg_rdata = 32'(addr_q);
            RA_CTRL:  reg_rdata = {15'b0, busy_q, ctrl_q};
            RA_STAT:  reg_rdata = {12'b0, type_q, 4'b0, err_q, 3'b0, cnt_q};
            RA_CAUSE: reg_rdata = {31'b0, cause_q};
            RA_EN:    reg_rdata = {31'b0, en_q};
            default: begin
                if (reg_addr[3:2] == 2'b10)
                    reg_rdata = tx_q[reg_addr[1:0]*32 +: 32];
                else if (reg_addr[3:2] == 2'b11)
                    reg_rdata = rx_q[reg_addr[1:0]*32 +: 32];
            end
        endcase
    end

    assign link_req       = busy_q;
    assign link_addr      = addr_q;
    assign link_cmd       = desc_q.cmd;
    assign link_mot       = desc_q.mot;
    assign link_addr_only = desc_q.addr_only;
    assign link_len       = desc_q.len;
    assign link_tx_data   = tx_q;
    assign irq            = cause_q & en_q;

endmodule

// File: rtl/aux_xact_chk.sv
module aux_xact_chk #(
    parameter int ADDR_W         = 20,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              link_req,
    input logic              link_rsp_valid,
    input logic [ADDR_W-1:0] link_addr,
    input logic [2:0]        link_cmd,
    input logic              link_mot,
    input logic              link_addr_only,
    input logic [4:0]        link_len,
    input logic [127:0]      link_tx_data,
    input logic              irq,
    input logic              cause_q,
    input logic              en_q
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !link_req)
            hi_cnt <= '0;
        else
            hi_cnt <= hi_cnt + CW'(1);
    end

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        link_req |-> (link_len <= 5'd16)); // R3
    AST_ADDR_ONLY_I2C: assert property (@(posedge clk) disable iff (rst)
        (link_req && link_addr_only) |-> (link_cmd >= 3'd2 && link_cmd <= 3'd4 && link_len == 5'd0)); // R4
    AST_NATIVE_NO_MOT: assert property (@(posedge clk) disable iff (rst)
        (link_req && link_cmd < 3'd2) |-> !link_mot); // R5
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(link_req) && !$past(link_rsp_valid) && ($past(hi_cnt) < CW'(TIMEOUT_CYCLES - 1))) |-> link_req); // R6
    AST_DESC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (link_req && $past(link_req)) |-> ($stable(link_addr) && $stable(link_len) && $stable(link_cmd) && $stable(link_tx_data))); // R7
    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        link_req |-> (hi_cnt < CW'(TIMEOUT_CYCLES))); // R9
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(link_req) |-> cause_q); // R11
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_q && cause_q)); // R11
endmodule

bind aux_xact_ctrl aux_xact_chk #(.ADDR_W(ADDR_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .link_req       (link_req),
    .link_rsp_valid (link_rsp_valid),
    .link_addr      (link_addr),
    .link_cmd       (link_cmd),
    .link_mot       (link_mot),
    .link_addr_only (link_addr_only),
    .link_len       (link_len),
    .link_tx_data   (link_tx_data),
    .irq            (irq),
    .cause_q        (cause_q),
    .en_q           (en_q)
);

// File: tb/tb_aux_xact_ctrl.sv
module tb_aux_xact_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int TMO        = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic link_req, link_mot, link_addr_only;
    logic [ADDR_W-1:0] link_addr;
    logic [2:0] link_cmd;
    logic [4:0] link_len;
    logic [127:0] link_tx_data;
    logic link_rsp_valid = 1'b0;
    logic [3:0] link_rsp_type = '0;
    logic [4:0] link_rsp_count = '0;
    logic [2:0] link_rsp_err = '0;
    logic [127:0] link_rx_data = '0;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] txw [4];
    logic [31:0] rxw [4];
    logic [3:0]  exp_err = '0;
    logic        en_model = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_xact_ctrl #(.ADDR_W(ADDR_W), .TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_req(link_req),
        .link_addr(link_addr), .link_cmd(link_cmd), .link_mot(link_mot),
        .link_addr_only(link_addr_only), .link_len(link_len),
        .link_tx_data(link_tx_data), .link_rsp_valid(link_rsp_valid),
        .link_rsp_type(link_rsp_type), .link_rsp_count(link_rsp_count),
        .link_rsp_err(link_rsp_err), .link_rx_data(link_rx_data), .irq(irq)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish act=hung exp=done");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [127:0] pack_bytes(input logic [31:0] w0, w1, w2, w3);
        logic [127:0] v;
        logic [31:0] ws [4];
        ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3;
        for (int k = 0; k < 16; k++)
            v[8*k +: 8] = ws[k/4][8*(k%4) +: 8];
        return v;
    endfunction

    function automatic logic [31:0] ctrl_word(input int cmd, input bit mot, input int len, input bit ao);
        logic [31:0] c;
        c = 32'h1_0000;
        c[14:12] = 3'(cmd);
        c[15] = mot;
        c[8] = ao;
        c[3:0] = ao ? 4'd0 : 4'(len - 1);
        return c;
    endfunction

    function automatic bit is_read(input int cmd);
        return (cmd == 1) || (cmd == 3);
    endfunction

    task automatic run_xact(input int cmd, input bit mot, input int len, input bit ao,
                            input int dly, input logic [3:0] rtype, input logic [4:0] rcnt,
                            input logic [2:0] rerr);
        logic [31:0] d;
        logic [31:0] a;
        logic [127:0] rxd;
        for (int i = 0; i < 4; i++) begin
            txw[i] = $urandom;
            wr(4'(8 + i), txw[i]);
        end
        a = $urandom;
        wr(4'd0, a);
        wr(4'd1, ctrl_word(cmd, mot, len, ao));
        chk("R6 req raised", link_req, 1);
        chk("R3 length", link_len, ao ? 0 : len);
        chk("R4 addr-only flag", link_addr_only, ao);
        chk("R5 command", link_cmd, cmd);
        chk("R5 mot", link_mot, mot && cmd >= 2);
        chk("R6 address", link_addr, a[ADDR_W-1:0]);
        chk("R2 tx packing", link_tx_data, pack_bytes(txw[0], txw[1], txw[2], txw[3]));
        rd(4'd1, d);
        chk("R6 go reads one", d[16], 1);
        repeat (dly) @(negedge clk);
        chk("R6 req held", link_req, 1);
        rxd = {$urandom, $urandom, $urandom, $urandom};
        link_rsp_valid = 1'b1; link_rsp_type = rtype; link_rsp_count = rcnt;
        link_rsp_err = rerr; link_rx_data = rxd;
        @(negedge clk);
        link_rsp_valid = 1'b0;
        chk("R6 req dropped", link_req, 0);
        rd(4'd1, d);
        chk("R6 go cleared", d[16], 0);
        exp_err = exp_err | {rerr, 1'b0};
        rd(4'd2, d);
        chk("R8 status", d, {12'b0, rtype, 4'b0, exp_err, 3'b0, rcnt});
        if (is_read(cmd))
            for (int w = 0; w < 4; w++)
                for (int b = 0; b < 4; b++)
                    rxw[w][8*b +: 8] = rxd[8*(4*w + b) +: 8];
        for (int w = 0; w < 4; w++) begin
            rd(4'(12 + w), d);
            chk("R8 R2 rx word", d, rxw[w]);
        end
        rd(4'd3, d);
        chk("R11 cause set", d, 1);
        chk("R11 irq gating", irq, en_model);
        wr(4'd3, 32'h1);
        chk("R11 cause cleared irq", irq, 0);
    endtask

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'h00c0ffee));
        for (int i = 0; i < 4; i++) rxw[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            chk("R1 reset reg", d, 0);
        end
        chk("R1 reset req", link_req, 0);
        chk("R1 reset irq", irq, 0);

        // R4 address-only with native codes is dropped; R5 unknown codes dropped
        wr(4'd1, ctrl_word(0, 0, 1, 1));
        chk("R4 native write addr-only no req", link_req, 0);
        wr(4'd1, ctrl_word(1, 0, 1, 1));
        chk("R4 native read addr-only no req", link_req, 0);
        rd(4'd1, d);
        chk("R4 go not set", d[16], 0);
        wr(4'd1, ctrl_word(5, 0, 4, 0));
        chk("R5 code 5 no req", link_req, 0);
        wr(4'd1, ctrl_word(7, 1, 4, 0));
        chk("R5 code 7 no req", link_req, 0);

        // directed boundaries: full length, single byte, address-only I2C
        wr(4'd4, 32'h1); en_model = 1'b1;
        run_xact(1, 0, 16, 0, 2, 4'h0, 5'd16, 3'b000);
        run_xact(0, 1, 1, 0, 0, 4'h1, 5'd0, 3'b000);
        run_xact(3, 1, 0, 1, 1, 4'h8, 5'd0, 3'b000);
        run_xact(4, 0, 0, 1, 3, 4'h4, 5'd0, 3'b010);

        // R10: write with bits 11:8 zero leaves errors and the rest alone
        wr(4'd2, 32'hFFFF_F0FF);
        rd(4'd2, d);
        chk("R10 status write ignored", d[11:8], exp_err);
        chk("R10 type unchanged", d[19:16], 4'h4);
        wr(4'd2, 32'h0000_0F00); exp_err = '0;
        rd(4'd2, d);
        chk("R10 errors cleared", d[11:8], 0);

        // R7 writes while busy are ignored
        wr(4'd0, 32'h12345);
        wr(4'd8, 32'hA5A5_0001);
        wr(4'd1, ctrl_word(2, 0, 3, 0));
        wr(4'd0, 32'h54321);
        wr(4'd8, 32'hDEAD_BEEF);
        wr(4'd1, ctrl_word(1, 0, 9, 0));
        chk("R7 address frozen", link_addr, 20'h12345);
        chk("R7 length frozen", link_len, 3);
        chk("R7 command frozen", link_cmd, 2);
        rd(4'd8, d);
        chk("R7 tx word frozen", d, 32'hA5A5_0001);
        rd(4'd1, d);
        chk("R7 ctrl frozen", d, {15'b0, 1'b1, ctrl_word(2, 0, 3, 0)[15:0]});

        // R11 collision: clear and completion on the same edge, set wins
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 32'h1;
        link_rsp_valid = 1'b1; link_rsp_type = 4'h0; link_rsp_count = 5'd3; link_rsp_err = 3'b0;
        @(negedge clk);
        reg_we = 1'b0; link_rsp_valid = 1'b0;
        rd(4'd3, d);
        chk("R11 set wins over clear", d, 1);
        chk("R11 irq after collision", irq, 1);
        wr(4'd4, 32'h0); en_model = 1'b0;
        chk("R11 irq masked", irq, 0);
        wr(4'd3, 32'h1);

        // R9 timeout
        wr(4'd1, ctrl_word(3, 0, 4, 0));
        n = 0;
        while (link_req) begin
            n++;
            @(negedge clk);
        end
        chk("R9 timeout window", n, TMO);
        rd(4'd2, d);
        chk("R9 timeout status", d, 32'h0000_0100);
        exp_err = 4'b0001;
        for (int w = 0; w < 4; w++) begin
            rd(4'(12 + w), d);
            chk("R9 rx untouched", d, rxw[w]);
        end
        wr(4'd3, 32'h1);

        // randomized transactions
        for (int t = 0; t < 40; t++) begin
            int cmd; bit ao; int len; logic [3:0] ty; logic [2:0] er;
            cmd = $urandom_range(0, 4);
            ao  = (cmd >= 2) && ($urandom_range(0, 4) == 0);
            len = $urandom_range(1, 16);
            case ($urandom_range(0, 4))
                0: ty = 4'h0; 1: ty = 4'h1; 2: ty = 4'h2; 3: ty = 4'h4; default: ty = 4'h8;
            endcase
            er = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0;
            if ($urandom_range(0, 1) == 1) begin
                en_model = ~en_model;
                wr(4'd4, {31'b0, en_model});
            end
            run_xact(cmd, 1'($urandom), len, ao, $urandom_range(0, 5), ty,
                     5'($urandom_range(0, 16)), er);
            if ($urandom_range(0, 2) == 0) begin
                wr(4'd2, 32'h0000_0F00); exp_err = '0;
            end
        end

        summary();
        $finish;
    end
endmodule